// File: doc/BRIEF.md
# Paged byte-write register decoder

This block turns completed 16-bit serial command frames into byte writes for a register file that is split into pages. Each register is 16 bits wide and is stored as two bytes: the low byte sits at an even byte address and the high byte at the next odd address. A full register update therefore takes two commands. The block keeps a current page number, which is shared by all pages and is set by writing byte address zero. Every other byte write leaves the block as a one-cycle strobe that carries the page, register index, byte lane and data.

Some register updates only take effect once the host ends the transaction. For this reason the block remembers the register touched by the most recent data write. It then issues a one-cycle commit strobe for that register on the next chip-select rising edge. Shifting the serial data in and producing read responses are handled elsewhere. Frame bit 15 selects write (1) or read (0). Bits [14:8] hold the byte address and bits [7:0] hold the data byte.

Top module: `paged_byte_decoder`

## Requirements
- R1: After a synchronous active-high reset, `cur_page` is 0 and `wr_stb` and `cmt_stb` are low.
- R2: A valid frame with bit 15 = 0 is a read. It produces no `wr_stb`, leaves `cur_page` unchanged, and neither arms nor clears a pending commit.
- R3: A write to byte address 0x00 loads frame bits [7:0] into `cur_page`, visible on the cycle after the frame. It behaves the same on every page and produces no `wr_stb`.
- R4: A write to byte address 0x01 is ignored. It produces no `wr_stb`, no page change and no pending commit.
- R5: A write to byte address 2 or above raises `wr_stb` for exactly the cycle after the frame. In that cycle `wr_page` is the page current at the frame, `wr_reg` is address bits [6:1], and `wr_data` is frame bits [7:0].
- R6: With `wr_stb` high, `wr_be` is 2'b01 for an even address (low byte) and 2'b10 for an odd address (high byte).
- R7: After a data byte write, the next `cs_rise` raises `cmt_stb` for one cycle, on the cycle after `cs_rise`. It carries that write's page and register index, and the pending commit is then cleared.
- R8: A `cs_rise` with no pending commit produces no `cmt_stb`.
- R9: When several data writes occur before `cs_rise`, the commit carries the most recent one.
- R10: When a data write and `cs_rise` arrive in the same cycle, the commit goes to the previously pending register. The new write stays pending for the next `cs_rise`.
- R11: Frames on consecutive cycles each produce their own `wr_stb` on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | A complete frame is present on `frame_word` |
| frame_word | input | 16 | Command: [15] write, [14:8] byte address, [7:0] data |
| cs_rise | input | 1 | Chip select returned high this cycle |
| cur_page | output | 8 | Current page number |
| wr_stb | output | 1 | One-cycle byte write strobe |
| wr_be | output | 2 | Byte lane: 01 low, 10 high |
| wr_page | output | 8 | Page of the byte write |
| wr_reg | output | 6 | Register index of the byte write |
| wr_data | output | 8 | Byte data |
| cmt_stb | output | 1 | One-cycle register commit strobe |
| cmt_page | output | 8 | Page of the committed register |
| cmt_reg | output | 6 | Register index being committed |

## Verification
The bench sends the decoder reads, page selects, the ignored page high byte, and low and high data bytes. Together these separate the four decode outcomes and both byte lanes. Chip-select edges are placed in four positions: after one write, after several writes, with no write pending, and in the same cycle as a write. These placements tell apart a commit that follows the latest write, a stale or spurious commit, and the correct ordering of arming and clearing. Back-to-back frames and a page change part-way through show that each strobe samples the page current at its own frame.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PAGE = 2'd1,
    CMD_DATA = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/pdec_cmd_decode.sv
module pdec_cmd_decode
  import pdec_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int FRAME_W = 1 + ADDR_W + DATA_W
) (
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_word,
  output cmd_kind_e          kind,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  data
);
  logic is_write;

  always_comb begin
    is_write = frame_valid && frame_word[FRAME_W-1];
    addr     = frame_word[FRAME_W-2:DATA_W];
    data     = frame_word[DATA_W-1:0];
    kind     = CMD_NONE;
    if (is_write) begin
      if (addr == '0)
        kind = CMD_PAGE;
      else if (addr[ADDR_W-1:1] != '0)
        kind = CMD_DATA;
    end
  end
endmodule

// File: rtl/pdec_page_reg.sv
module pdec_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic [PAGE_W-1:0] value,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (rst)
      page <= '0;
    else if (set)
      page <= value;
  end

  a_r3_page_loads: assert property (@(posedge clk) disable iff (rst)
    set |=> page == $past(value));
  a_r3_page_holds: assert property (@(posedge clk) disable iff (rst)
    !set |=> $stable(page));
endmodule

// File: rtl/pdec_commit_tracker.sv
module pdec_commit_tracker #(
  parameter int PAGE_W = 8,
  parameter int REG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [PAGE_W-1:0] arm_page,
  input  logic [REG_W-1:0]  arm_reg,
  input  logic              cs_rise,
  output logic              cmt_stb,
  output logic [PAGE_W-1:0] cmt_page,
  output logic [REG_W-1:0]  cmt_reg
);
  logic              pend;
  logic [PAGE_W-1:0] pend_page;
  logic [REG_W-1:0]  pend_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_page <= '0;
      pend_reg  <= '0;
      cmt_stb   <= 1'b0;
      cmt_page  <= '0;
      cmt_reg   <= '0;
    end else begin
      cmt_stb <= cs_rise && pend;
      if (cs_rise) begin
        cmt_page <= pend_page;
        cmt_reg  <= pend_reg;
      end
      if (arm) begin
        pend      <= 1'b1;
        pend_page <= arm_page;
        pend_reg  <= arm_reg;
      end else if (cs_rise) begin
        pend <= 1'b0;
      end
    end
  end

  a_r8_commit_needs_cs: assert property (@(posedge clk) disable iff (rst)
    cmt_stb |-> $past(cs_rise));
  a_r7_commit_clears: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !arm) |=> !pend);
endmodule

// File: rtl/paged_byte_decoder.sv
module paged_byte_decoder
  import pdec_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  localparam int FRAME_W = 1 + ADDR_W + DATA_W,
  localparam int REG_W   = ADDR_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic               cs_rise,
  output logic [PAGE_W-1:0]  cur_page,
  output logic               wr_stb,
  output logic [1:0]         wr_be,
  output logic [PAGE_W-1:0]  wr_page,
  output logic [REG_W-1:0]   wr_reg,
  output logic [DATA_W-1:0]  wr_data,
  output logic               cmt_stb,
  output logic [PAGE_W-1:0]  cmt_page,
  output logic [REG_W-1:0]   cmt_reg
);
  cmd_kind_e         kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;

  pdec_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .frame_valid(frame_valid),
    .frame_word (frame_word),
    .kind       (kind),
    .addr       (addr),
    .data       (data)
  );

  pdec_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk  (clk),
    .rst  (rst),
    .set  (kind == CMD_PAGE),
    .value(data[PAGE_W-1:0]),
    .page (cur_page)
  );

  pdec_commit_tracker #(.PAGE_W(PAGE_W), .REG_W(REG_W)) u_cmt (
    .clk     (clk),
    .rst     (rst),
    .arm     (kind == CMD_DATA),
    .arm_page(cur_page),
    .arm_reg (addr[ADDR_W-1:1]),
    .cs_rise (cs_rise),
    .cmt_stb (cmt_stb),
    .cmt_page(cmt_page),
    .cmt_reg (cmt_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      wr_be   <= 2'b00;
      wr_page <= '0;
      wr_reg  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= (kind == CMD_DATA);
      if (kind == CMD_DATA) begin
        wr_be   <= addr[0] ? 2'b10 : 2'b01;
        wr_page <= cur_page;
        wr_reg  <= addr[ADDR_W-1:1];
        wr_data <= data;
      end
    end
  end

  a_r2_read_inert: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !frame_word[FRAME_W-1]) |=> (!wr_stb && $stable(cur_page)));
  a_r4_page_hi_ignored: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_word[FRAME_W-1] && frame_word[FRAME_W-2:DATA_W] == 1)
      |=> (!wr_stb && $stable(cur_page)));
  a_r5_stb_needs_write: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(frame_valid && frame_word[FRAME_W-1]));
  a_r6_lane_onehot: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $countones(wr_be) == 1);
endmodule

// File: tb/test_paged_byte_decoder.sv
module test_paged_byte_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_valid = 1'b0;
  logic [15:0] frame_word = '0;
  logic        cs_rise = 1'b0;
  logic [7:0]  cur_page, wr_page, wr_data, cmt_page;
  logic        wr_stb, cmt_stb;
  logic [1:0]  wr_be;
  logic [5:0]  wr_reg, cmt_reg;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  paged_byte_decoder i_paged_byte_decoder (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_word(frame_word),
    .cs_rise(cs_rise), .cur_page(cur_page), .wr_stb(wr_stb), .wr_be(wr_be),
    .wr_page(wr_page), .wr_reg(wr_reg), .wr_data(wr_data), .cmt_stb(cmt_stb),
    .cmt_page(cmt_page), .cmt_reg(cmt_reg)
  );

  // Behavioural reference model
  int m_page = 0;
  bit m_stb = 0;
  int m_be = 0, m_wpage = 0, m_wreg = 0, m_wdata = 0;
  bit m_cmt = 0;
  int m_cpage = 0, m_creg = 0;
  bit m_pend = 0;
  int m_ppage = 0, m_preg = 0;

  always @(posedge clk) begin
    int a, d;
    bit wrote;
    if (rst) begin
      m_page = 0; m_stb = 0; m_cmt = 0; m_pend = 0;
    end else begin
      a = frame_word[14:8];
      d = frame_word[7:0];
      m_cmt = cs_rise && m_pend;
      if (m_cmt) begin m_cpage = m_ppage; m_creg = m_preg; end
      m_stb = 0;
      wrote = 0;
      if (frame_valid && frame_word[15]) begin
        if (a == 0) m_page = d;
        else if (a >= 2) begin
          m_stb = 1; wrote = 1;
          m_be = (a % 2 == 1) ? 2 : 1;
          m_wpage = m_page; m_wreg = a / 2; m_wdata = d;
          m_pend = 1; m_ppage = m_page; m_preg = a / 2;
        end
      end
      if (cs_rise && !wrote) m_pend = 0;
    end
  end

  task automatic check(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 cur_page", cur_page, m_page);
      check("R5 wr_stb", wr_stb, m_stb);
      if (m_stb) begin
        check("R6 wr_be", wr_be, m_be);
        check("R5 wr_page", wr_page, m_wpage);
        check("R5 wr_reg", wr_reg, m_wreg);
        check("R5 wr_data", wr_data, m_wdata);
      end
      check("R7 cmt_stb", cmt_stb, m_cmt);
      if (m_cmt) begin
        check("R7 cmt_page", cmt_page, m_cpage);
        check("R7 cmt_reg", cmt_reg, m_creg);
      end
    end
  end

  task automatic step(bit fv, logic [15:0] w, bit cs);
    @(negedge clk);
    frame_valid = fv; frame_word = w; cs_rise = cs;
    @(negedge clk);
    frame_valid = 1'b0; cs_rise = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 page", cur_page, 0);
    check("R1 wr_stb", wr_stb, 0);
    check("R1 cmt_stb", cmt_stb, 0);

    step(1, 16'h0312, 0);
    check("R2 no strobe", wr_stb, 0);
    check("R2 page", cur_page, 0);

    step(1, 16'h8003, 0);
    check("R3 page set", cur_page, 3);
    check("R3 no strobe", wr_stb, 0);

    step(1, 16'h8155, 0);
    check("R4 no strobe", wr_stb, 0);
    check("R4 page", cur_page, 3);
    step(0, 16'h0, 1);
    check("R4 no commit", cmt_stb, 0);

    step(1, 16'h8608, 0);
    check("R5 strobe", wr_stb, 1);
    check("R6 low lane", wr_be, 2'b01);
    check("R5 reg", wr_reg, 3);
    check("R5 data", wr_data, 8'h08);
    check("R5 page", wr_page, 3);
    @(negedge clk);
    check("R5 one cycle", wr_stb, 0);

    step(1, 16'h8700, 0);
    check("R6 high lane", wr_be, 2'b10);

    step(0, 16'h0, 1);
    check("R7 commit", cmt_stb, 1);
    check("R7 reg", cmt_reg, 3);
    check("R7 page", cmt_page, 3);
    @(negedge clk);
    check("R7 one cycle", cmt_stb, 0);

    step(0, 16'h0, 1);
    check("R8 no pending", cmt_stb, 0);

    step(1, 16'h8a11, 0);
    step(1, 16'h9022, 0);
    step(0, 16'h0, 1);
    check("R9 latest", cmt_reg, 8);
    check("R9 strobe", cmt_stb, 1);

    step(1, 16'h8005, 0);
    check("R3 page on page 3", cur_page, 5);

    step(1, 16'h8c01, 0);
    step(1, 16'h8e02, 1);
    check("R10 old commit", cmt_reg, 6);
    check("R10 page", cmt_page, 5);
    step(0, 16'h0, 1);
    check("R10 new kept", cmt_stb, 1);
    check("R10 new reg", cmt_reg, 7);

    step(1, 16'h8c03, 0);
    step(1, 16'h0c00, 0);
    step(0, 16'h0, 1);
    check("R2 read keeps pending", cmt_stb, 1);

    @(negedge clk);
    frame_valid = 1'b1; frame_word = 16'h8a01;
    @(negedge clk);
    frame_word = 16'h8b02;
    check("R11 first", wr_stb, 1);
    check("R11 first lane", wr_be, 2'b01);
    @(negedge clk);
    frame_valid = 1'b0;
    check("R11 second", wr_stb, 1);
    check("R11 second lane", wr_be, 2'b10);
    check("R11 second data", wr_data, 8'h02);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule